// File: doc/BRIEF.md
# Interlocked Read Handshake Master

This block lets a synchronous core read from a slave on a bus that has no shared clock. The core presents an address with a request. The block drives the address and a read-enable line onto the bus. It holds them for a fixed settle interval, then pulls an active-low strobe. It waits for the slave's active-low acknowledge and captures the data the slave holds on the bus. After that it releases the strobe and waits for the slave to release the acknowledge. Only then does it accept another request. Every phase is interlocked, so the slave may take any time to answer.

The acknowledge from the bus passes through a two-flop synchroniser before the control state machine uses it. The read data needs no synchroniser of its own, because the slave keeps the data stable for as long as the acknowledge is low. A cycle counter bounds the wait for the acknowledge. When the limit expires, the block releases the strobe and reports the read with an error flag.

Top module: `hsk_read_master`

## Requirements
- R1: During and right after synchronous reset, bus_syn_n is 1, bus_rd_en is 0 and rsp_valid is 0. Once reset is released with bus_ack_n high, req_ready is 1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. From the next cycle, bus_addr equals the accepted address and bus_rd_en is 1, while bus_syn_n stays 1. bus_rd_en is 1 whenever bus_syn_n is 0.
- R3: bus_syn_n goes to 0 exactly SETTLE_CYC cycles after the cycle in which bus_rd_en first becomes 1.
- R4: bus_addr does not change while bus_syn_n is 0.
- R5: When the slave pulls bus_ack_n low with data on bus_data, rsp_valid rises 4 clock edges later with rsp_data equal to that data and rsp_err 0. On the same edge, bus_syn_n returns to 1 and bus_rd_en to 0.
- R6: Apart from a timeout, bus_syn_n returns to 1 only together with a response, never while the acknowledge is still unseen.
- R7: req_ready is 0 from acceptance until bus_ack_n is high again. It returns to 1 on the third clock edge after bus_ack_n goes high.
- R8: If no acknowledge arrives, bus_syn_n stays 0 for exactly TIMEOUT_CYC cycles. It then returns to 1 on the same edge that raises rsp_valid with rsp_err 1. With bus_ack_n high, req_ready is 1 in that same cycle.
- R9: While bus_ack_n is held low in idle, req_ready stays 0 and a presented request is ignored: bus_rd_en stays 0.
- R10: rsp_valid is a one-cycle pulse, raised once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core read request |
| req_addr | input | AW | Address of the requested read |
| req_ready | output | 1 | Block can take a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse: read finished |
| rsp_data | output | DW | Captured read data (zero on error) |
| rsp_err | output | 1 | Read ended by timeout |
| bus_addr | output | AW | Address driven to the bus |
| bus_rd_en | output | 1 | Read control line, high for the whole transaction |
| bus_syn_n | output | 1 | Active-low strobe to the slave |
| bus_ack_n | input | 1 | Active-low acknowledge from the slave |
| bus_data | input | DW | Read data from the slave |

## Verification
A control state that slips a phase shows at the bus pins within a cycle or two. The strobe then falls too early or late against the read-enable line, or it rises without a response pulse. A synchroniser with a stage missing or added moves the response and the return of req_ready by one cycle, so the bench checks the exact latency from every acknowledge edge. A counter off by one shifts the strobe's low time on a timeout by exactly one cycle, and the bench measures that low time in every timed-out read.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_WAIT   = 3'd2,
        ST_CAPT   = 3'd3,
        ST_REL    = 3'd4
    } hsk_state_e;

    // Bus control lines driven by the master
    typedef struct packed {
        logic rd_en;
        logic syn_n;
    } bus_ctl_t;

    localparam bus_ctl_t CTL_IDLE = '{rd_en: 1'b0, syn_n: 1'b1};

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int at_least_one(input int a);
        return (a < 1) ? 1 : a;
    endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hsk_ctrl.sv
module hsk_ctrl
    import hsk_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int SETTLE_CYC  = 2,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    input  logic          ack_seen,
    input  logic [DW-1:0] bus_data,
    output logic [AW-1:0] bus_addr,
    output bus_ctl_t      ctl,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_err
);
    localparam int SETTLE_N = at_least_one(SETTLE_CYC);
    localparam int TO_N     = at_least_one(TIMEOUT_CYC);
    localparam int CW       = $clog2(max_of(SETTLE_N, TO_N) + 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_N - 1);
    localparam logic [CW-1:0] TO_LAST     = CW'(TO_N - 1);

    hsk_state_e    state;
    logic [CW-1:0] cnt;

    assign req_ready = (state == ST_IDLE) && !ack_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            bus_addr  <= '0;
            ctl       <= CTL_IDLE;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid && req_ready) begin
                        bus_addr  <= req_addr;
                        ctl.rd_en <= 1'b1;
                        cnt       <= '0;
                        state     <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (cnt == SETTLE_LAST) begin
                        cnt       <= '0;
                        ctl.syn_n <= 1'b0;
                        state     <= ST_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (ack_seen) begin
                        state <= ST_CAPT;
                    end else if (cnt == TO_LAST) begin
                        ctl       <= CTL_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_err   <= 1'b1;
                        rsp_data  <= '0;
                        state     <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CAPT: begin
                    rsp_data  <= bus_data;
                    rsp_err   <= 1'b0;
                    rsp_valid <= 1'b1;
                    ctl       <= CTL_IDLE;
                    state     <= ST_REL;
                end
                ST_REL: begin
                    if (!ack_seen) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hsk_read_master.sv
module hsk_read_master
    import hsk_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int SETTLE_CYC  = 2,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_err,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd_en,
    output logic          bus_syn_n,
    input  logic          bus_ack_n,
    input  logic [DW-1:0] bus_data
);
    logic     ack_n_s;
    bus_ctl_t ctl;

    hsk_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_ack_n),
        .q   (ack_n_s)
    );

    hsk_ctrl #(
        .AW(AW), .DW(DW), .SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .ack_seen  (~ack_n_s),
        .bus_data  (bus_data),
        .bus_addr  (bus_addr),
        .ctl       (ctl),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_err   (rsp_err)
    );

    assign bus_rd_en = ctl.rd_en;
    assign bus_syn_n = ctl.syn_n;
endmodule

// File: rtl/hsk_read_master_chk.sv
module hsk_read_master_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd_en,
    input logic          bus_syn_n,
    input logic          rsp_valid
);
    assert_strobe_inside_read_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_syn_n |-> bus_rd_en);

    assert_addr_held_R4: assert property (@(posedge clk) disable iff (rst)
        !bus_syn_n |=> (bus_syn_n || $stable(bus_addr)));

    assert_release_with_rsp_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_syn_n) |-> rsp_valid);

    assert_ready_only_idle_R7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bus_syn_n && !bus_rd_en));

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind hsk_read_master hsk_read_master_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .bus_addr  (bus_addr),
    .bus_rd_en (bus_rd_en),
    .bus_syn_n (bus_syn_n),
    .rsp_valid (rsp_valid)
);

// File: tb/tb_hsk_read_master.sv
module tb_hsk_read_master;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SETTLE = 3;
    localparam int TO = 40;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          rsp_err;
    logic [AW-1:0] bus_addr;
    logic          bus_rd_en;
    logic          bus_syn_n;
    logic          bus_ack_n = 1'b1;
    logic [DW-1:0] bus_data = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsk_read_master #(
        .AW(AW), .DW(DW), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TO), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .bus_addr(bus_addr), .bus_rd_en(bus_rd_en),
        .bus_syn_n(bus_syn_n), .bus_ack_n(bus_ack_n), .bus_data(bus_data)
    );

    function automatic logic [DW-1:0] slave_word(input logic [AW-1:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction

    task automatic chk(input bit ok, input string req,
                       input longint unsigned act, input longint unsigned exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One complete read; respond=0 models a slave that never answers
    task automatic do_read(input logic [AW-1:0] addr, input int dly,
                           input int rdly, input bit respond);
        int n;
        @(negedge clk);
        chk(req_ready == 1'b1, "R7 ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(bus_rd_en && bus_syn_n && bus_addr == addr, "R2 address and read line",
            {bus_rd_en, bus_syn_n, bus_addr}, {2'b11, addr});
        chk(req_ready == 1'b0, "R7 ready drops on accept", req_ready, 0);
        n = 0;
        while (bus_syn_n && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(n == SETTLE, "R3 settle interval", n, SETTLE);
        if (respond) begin
            for (int i = 0; i < dly; i++) begin
                @(negedge clk);
                if (!bus_syn_n == 1'b0 || bus_addr != addr)
                    chk(1'b0, "R6 strobe/addr held while waiting", {bus_syn_n, bus_addr}, {1'b0, addr});
            end
            bus_data  = slave_word(addr);
            bus_ack_n = 1'b0;
            n = 0;
            while (!rsp_valid && n < 20) begin
                @(negedge clk);
                n++;
            end
            chk(n == 4, "R5 ack to response latency", n, 4);
            chk(rsp_data == slave_word(addr) && !rsp_err, "R5 captured data",
                {rsp_err, rsp_data}, {1'b0, slave_word(addr)});
            chk(bus_syn_n && !bus_rd_en, "R5 strobe released with response",
                {bus_syn_n, bus_rd_en}, 2'b10);
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R10 single response pulse", rsp_valid, 0);
            for (int i = 0; i < rdly; i++) begin
                @(negedge clk);
                chk(req_ready == 1'b0, "R7 ready low while ack held", req_ready, 0);
            end
            bus_ack_n = 1'b1;
            bus_data  = '0;
            n = 0;
            while (!req_ready && n < 20) begin
                @(negedge clk);
                n++;
            end
            chk(n == 3, "R7 ready after ack release", n, 3);
        end else begin
            n = 0;
            while (!rsp_valid && n < 200) begin
                if (!bus_syn_n) n++;
                @(negedge clk);
            end
            chk(n == TO, "R8 strobe low time on timeout", n, TO);
            chk(rsp_err && bus_syn_n && !bus_rd_en && req_ready,
                "R8 error response and release",
                {rsp_err, bus_syn_n, bus_rd_en, req_ready}, 4'b1101);
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R10 single error pulse", rsp_valid, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        chk(bus_syn_n && !bus_rd_en && !rsp_valid, "R1 reset outputs",
            {bus_syn_n, bus_rd_en, rsp_valid}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

        // Directed: quick slave, then slow slave
        do_read(16'h0000, 0, 0, 1'b1);
        do_read(16'hFFFF, 10, 6, 1'b1);

        // Directed: timeout, then a normal read to show recovery
        do_read(16'h1234, 0, 0, 1'b0);
        do_read(16'h4321, 2, 1, 1'b1);

        // R9: acknowledge stuck low in idle blocks requests
        @(negedge clk);
        bus_ack_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b0, "R9 ready low with stuck ack", req_ready, 0);
        req_valid = 1'b1;
        req_addr  = 16'hBEEF;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(bus_rd_en == 1'b0 && req_ready == 1'b0, "R9 request ignored",
                {bus_rd_en, req_ready}, 2'b00);
        end
        req_valid = 1'b0;
        bus_ack_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready after ack released", req_ready, 1);

        // Random reads with a few timeouts mixed in
        for (int k = 0; k < 30; k++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            do_read(a, int'($urandom_range(0, 12)), int'($urandom_range(0, 5)),
                    ($urandom_range(0, 7) != 0));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule